// File: doc/BRIEF.md
# Fixed-Page Return Stack Pointer

This block produces the memory address used by an 8-bit processor when it saves and restores subroutine return addresses. A small pointer register supplies the low address bits. Every bit above it is forced to one, so with the default sizes all stack traffic stays inside the top sixteen bytes of a 64 KiB space, FFF0 to FFFF. A return address is two bytes wide, so the page holds eight nested calls.

The sequencer pulses `push_i` once per byte saved and `pop_i` once per byte restored. A push uses the current address for its write and then steps the pointer down. A pop steps the pointer up and then uses the new address for its read. `oe_i` gates the address onto the shared address bus. The pointer tracks a full state of its own, so a sixteenth byte can be stored without losing track. A push into a full page and a pop from an empty page are refused, and each raises its own sticky flag.

Top module: `stack_ptr_fixed_page`

## Requirements
- R1: After the asynchronous active-low reset the pointer is 0xF, the page is empty, `ovf_o` and `udf_o` are 0, and with `oe_i` high `addr_o` reads 16'hFFFF.
- R2: While `oe_i` is high, every `addr_o` bit above the pointer field (bits 15..4 by default) is 1, and bits 3..0 equal the pointer.
- R3: A push (`push_i`=1, `pop_i`=0) on a page that is not full lowers the pointer by one at the clock edge. A push at pointer 0x0 sets the pointer to 0xF and marks the page full.
- R4: A pop (`pop_i`=1, `push_i`=0) on a page that is not empty raises the pointer by one at the clock edge. A pop on a full page moves the pointer from 0xF to 0x0 and clears full.
- R5: When `push_i` and `pop_i` are both 1, the pointer, the full state and both flags are left unchanged.
- R6: While `oe_i` is low, `addr_o` is all zeros. `oe_i` has no effect on the pointer.
- R7: A push on a full page leaves the pointer unchanged and sets `ovf_o`. The flag stays at 1 until reset.
- R8: A pop on an empty page (pointer 0xF, not full) leaves the pointer unchanged and sets `udf_o`. The flag stays at 1 until reset.
- R9: Starting from reset, sixteen pushes use the addresses FFFF down to FFF0 in that order without raising `ovf_o`. Sixteen pops after them read FFF0 up to FFFF without raising `udf_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Store one byte, then step the pointer down |
| pop_i | input | 1 | Step the pointer up before a byte is read |
| oe_i | input | 1 | Drives the address onto the bus while high |
| addr_o | output | ADDR_W (16) | Stack address, all zeros while not enabled |
| ovf_o | output | 1 | Sticky flag: push refused on a full page |
| udf_o | output | 1 | Sticky flag: pop refused on an empty page |

## Verification
The bench builds the block with its defaults, ADDR_W=16 and PTR_W=4. With these sizes a 16-byte page is filled and drained in a few dozen cycles. This brings both refusal boundaries within reach, along with the full-page wrap from 0x0 to 0xF and back, and every pointer value on the way. The same sizes allow a direct check that the upper twelve address bits are forced to one, and that the bus is silent while output-enable is low, both before and after pointer moves.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_PUSH = 2'd1,
    SP_POP  = 2'd2
  } sp_op_e;
endpackage

// File: rtl/sp_op_decode.sv
module sp_op_decode
  import sp_pkg::*;
(
  input  logic   push_i,
  input  logic   pop_i,
  output sp_op_e op_o
);
  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = SP_PUSH;
      2'b01:   op_o = SP_POP;
      default: op_o = SP_HOLD; // idle or conflicting request
    endcase
  end
endmodule

// File: rtl/sp_guard.sv
module sp_guard
  import sp_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  sp_op_e           op_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             full_i,
  output logic             step_en_o,
  output logic             ovf_hit_o,
  output logic             udf_hit_o
);
  localparam logic [PTR_W-1:0] PtrTop = {PTR_W{1'b1}};

  logic empty;
  assign empty     = (ptr_i == PtrTop) && !full_i;
  assign ovf_hit_o = (op_i == SP_PUSH) && full_i;
  assign udf_hit_o = (op_i == SP_POP) && empty;
  assign step_en_o = (op_i != SP_HOLD) && !ovf_hit_o && !udf_hit_o;
endmodule

// File: rtl/sp_counter.sv
module sp_counter
  import sp_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sp_op_e           op_i,
  input  logic             step_en_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] PtrTop  = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] PtrOne  = {{(PTR_W-1){1'b0}}, 1'b1};
  localparam logic [PTR_W-1:0] PtrZero = '0;

  logic [PTR_W-1:0] ptr_d, ptr_q;
  logic             full_d, full_q;

  always_comb begin
    ptr_d  = ptr_q;
    full_d = full_q;
    if (step_en_i) begin
      if (op_i == SP_PUSH) begin
        ptr_d = ptr_q - PtrOne;            // wraps 0 -> top
        if (ptr_q == PtrZero) full_d = 1'b1;
      end else if (op_i == SP_POP) begin
        ptr_d  = ptr_q + PtrOne;           // wraps top -> 0 when leaving full
        full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= PtrTop;
      full_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = full_q;
endmodule

// File: rtl/sp_flags.sv
module sp_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_hit_i,
  input  logic udf_hit_i,
  output logic ovf_o,
  output logic udf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      if (ovf_hit_i) ovf_o <= 1'b1;
      if (udf_hit_i) udf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sp_addr_drive.sv
module sp_addr_drive #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PTR_W  = 4
) (
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              oe_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned PAGE_W = ADDR_W - PTR_W;

  logic [ADDR_W-1:0] addr_full;

  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_bit
      if (gi >= PTR_W) begin : g_page
        assign addr_full[gi] = 1'b1;
      end else begin : g_ptr
        assign addr_full[gi] = ptr_i[gi];
      end
    end
  endgenerate

  assign addr_o = oe_i ? addr_full : {ADDR_W{1'b0}};

  initial begin
    if (PAGE_W < 1) $error("ADDR_W must exceed PTR_W");
  end
endmodule

// File: rtl/stack_ptr_fixed_page.sv
module stack_ptr_fixed_page
  import sp_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PTR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              oe_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ovf_o,
  output logic              udf_o
);
  sp_op_e           op;
  logic [PTR_W-1:0] ptr_q;
  logic             full_q;
  logic             step_en, ovf_hit, udf_hit;

  sp_op_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  sp_guard #(.PTR_W(PTR_W)) u_guard (
    .op_i      (op),
    .ptr_i     (ptr_q),
    .full_i    (full_q),
    .step_en_o (step_en),
    .ovf_hit_o (ovf_hit),
    .udf_hit_o (udf_hit)
  );

  sp_counter #(.PTR_W(PTR_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .step_en_i (step_en),
    .ptr_o     (ptr_q),
    .full_o    (full_q)
  );

  sp_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_hit_i (ovf_hit),
    .udf_hit_i (udf_hit),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
  );

  sp_addr_drive #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_drv (
    .ptr_i  (ptr_q),
    .oe_i   (oe_i),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/stack_ptr_fixed_page_chk.sv
module stack_ptr_fixed_page_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PTR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic              pop_i,
  input logic              oe_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ovf_o,
  input logic              udf_o,
  input logic [PTR_W-1:0]  ptr_i,
  input logic              full_i
);
  localparam logic [PTR_W-1:0] PtrTop = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] PtrOne = {{(PTR_W-1){1'b0}}, 1'b1};

  AST_PAGE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> (&addr_o[ADDR_W-1:PTR_W]) && (addr_o[PTR_W-1:0] == ptr_i)); // R2

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (addr_o == '0)); // R6

  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_i) |=> (ptr_i == $past(ptr_i) - PtrOne)); // R3

  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && (full_i || ptr_i != PtrTop)) |=> (ptr_i == $past(ptr_i) + PtrOne) && !full_i); // R4

  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(ptr_i) && $stable(full_i) && $stable(ovf_o) && $stable(udf_o)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(push_i && !pop_i && full_i)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udf_o) |-> $past(pop_i && !push_i && !full_i && ptr_i == PtrTop)); // R8

  AST_UDF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o); // R8
endmodule

bind stack_ptr_fixed_page stack_ptr_fixed_page_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .push_i (push_i),
  .pop_i  (pop_i),
  .oe_i   (oe_i),
  .addr_o (addr_o),
  .ovf_o  (ovf_o),
  .udf_o  (udf_o),
  .ptr_i  (ptr_q),
  .full_i (full_q)
);

// File: tb/stack_ptr_fixed_page_test.sv
module stack_ptr_fixed_page_test;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned PTR_W  = 4;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              ovf;
    logic              udf;
    string             req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0, oe = 1'b1;
  logic [ADDR_W-1:0] addr;
  logic ovf, udf;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  exp_t q[$];

  // reference state
  logic [PTR_W-1:0] m_ptr;
  logic m_full, m_ovf, m_udf;

  always #2.5 clk = ~clk;

  stack_ptr_fixed_page #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop), .oe_i(oe),
    .addr_o(addr), .ovf_o(ovf), .udf_o(udf)
  );

  function automatic logic [ADDR_W-1:0] exp_addr(logic en);
    return en ? {{(ADDR_W-PTR_W){1'b1}}, m_ptr} : '0;
  endfunction

  task automatic compare(exp_t e);
    vectors++;
    if (addr !== e.addr || ovf !== e.ovf || udf !== e.udf) begin
      fails++;
      $display("FAIL %s: addr=%h ovf=%b udf=%b expected addr=%h ovf=%b udf=%b",
               e.req, addr, ovf, udf, e.addr, e.ovf, e.udf);
    end
  endtask

  // monitor: consumes expectations queued after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) compare(q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; push = 1'b0; pop = 1'b0; oe = 1'b1;
    #1;
    m_ptr = '1; m_full = 1'b0; m_ovf = 1'b0; m_udf = 1'b0;
    compare('{exp_addr(1'b1), 1'b0, 1'b0, "R1"});
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare('{exp_addr(1'b1), 1'b0, 1'b0, "R1"});
  endtask

  task automatic step(logic p, logic o, logic en, string req);
    @(negedge clk);
    push = p; pop = o; oe = en;
    @(posedge clk);
    #1;
    if (p && !o) begin
      if (m_full) m_ovf = 1'b1;
      else if (m_ptr == '0) begin m_ptr = '1; m_full = 1'b1; end
      else m_ptr = m_ptr - 1'b1;
    end else if (o && !p) begin
      if (m_full) begin m_ptr = m_ptr + 1'b1; m_full = 1'b0; end
      else if (m_ptr == '1) m_udf = 1'b1;
      else m_ptr = m_ptr + 1'b1;
    end
    q.push_back('{exp_addr(en), m_ovf, m_udf, req});
  endtask

  task automatic idle_check(string req);
    step(1'b0, 1'b0, 1'b1, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();                                  // R1
    step(1'b0, 1'b1, 1'b1, "R8");                // pop on empty: refused, udf
    idle_check("R8");                            // sticky
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1, "R3_R9");  // R2 addresses FFFx
    idle_check("R9");                            // full, no ovf
    step(1'b1, 1'b0, 1'b1, "R7");                // push on full: refused
    step(1'b0, 1'b0, 1'b1, "R7");                // stays set
    step(1'b0, 1'b1, 1'b1, "R4");                // leave full: FFF0
    step(1'b1, 1'b1, 1'b1, "R5");                // both: hold
    step(1'b0, 1'b1, 1'b0, "R6");                // bus silent, pop still lands
    idle_check("R6");
    step(1'b1, 1'b0, 1'b0, "R6");
    idle_check("R6");
    do_reset();
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 16; i++) step(1'b0, 1'b1, 1'b1, "R4_R9"); // drain without udf
    step(1'b1, 1'b1, 1'b1, "R5");                // both at empty: no flag
    step(1'b0, 1'b1, 1'b1, "R8");                // one pop too many
    step(1'b1, 1'b0, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b0, "R6");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule